// File: doc/BRIEF.md
# Prescaled PWM Channel with Edge Points

This block produces one pulse-width-modulated output bit. The input clock is first divided by a linear stage and then by a power-of-two stage. Each resulting tick advances an 8-bit period counter. A programmable rising point and falling point on that counter mark where the active part of each period starts and ends. The window wraps across the period end when the falling point is below the rising point. When the two points are equal, the window covers the whole period.

Software configures the channel with two write-only 32-bit words, a control word and a duty word. The control word holds both prescaler fields and four flags: pin enable, inversion, counter run and a sync-disable select. The duty word holds both edge points and the period length. Divider, period and edge values first land in staging registers. They move to the active set at the next period boundary. If sync is disabled, or the counter is stopped, they move on every clock instead. The flags act directly.

Top module: `pwm_edge_channel`

## Requirements
- R1: The output period is (L+1) × 2^E × (P+1) input clocks, where L is the linear divider, E is the power-of-two exponent and P is the period field.
- R2: While running, the period counter advances once per prescaler tick, from 0 up to P. After P it returns to 0.
- R3: Control word fields are: L in bits 7:0, E in bits 11:8, pin enable in bit 12, inversion in bit 14, run in bit 16 and sync-disable in bit 17. Duty word fields are: rising point in bits 7:0, falling point in bits 15:8 and P in bits 31:24.
- R4: While pin enable is 0, pwm_o is 0 whatever the other settings are, inversion included.
- R5: While run is 0, both prescaler stages and the period counter are held at zero and the window is inactive. Clearing run stops the pulse on the next clock, without finishing the current period.
- R6: A change of the inversion bit shows at pwm_o one clock after the write, with no wait for a boundary.
- R7: When the rising point equals the falling point, the window is active for the whole period.
- R8: With sync-disable 0 and run 1, written divider, period and edge values take effect only at the clock where the counter wraps from P to 0.
- R9: With sync-disable 1, or with run 0, the staged values take effect on the clock after the write.
- R10: When rising < falling, the window is active for counts c with rising ≤ c < falling. When rising > falling, it is active for c ≥ rising or c < falling.
- R11: pwm_o is registered: it equals pin_en AND (inversion XOR (window AND run)), evaluated in the previous cycle. It is 0 after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_ctrl | input | 1 | Write strobe for the control word |
| wr_duty | input | 1 | Write strobe for the duty word |
| wdata | input | 32 | Write data shared by both words |
| pwm_o | output | 1 | Registered PWM output |

## Verification
The assertions take for granted that the write strobes are single-cycle pulses on clean clock-aligned data. They also take for granted that reset is held long enough to clear every register before the first check. The bench drives strobes and data only on the falling clock edge and holds reset for several cycles. It keeps random divider and period fields small, so that many full periods, boundaries and mid-period updates fall inside each run. All four flags are randomised freely.

// File: rtl/pwm_edge_pkg.sv
package pwm_edge_pkg;
  localparam int LIN_W = 8;
  localparam int EXP_W = 4;
  localparam int CNT_W = 8;
  localparam int POW_W = (1 << EXP_W) - 1;

  // control word bit positions
  localparam int CB_LIN   = 0;
  localparam int CB_EXP   = 8;
  localparam int CB_PIN   = 12;
  localparam int CB_INV   = 14;
  localparam int CB_RUN   = 16;
  localparam int CB_NOSYN = 17;
  // duty word bit positions
  localparam int DB_RISE  = 0;
  localparam int DB_FALL  = 8;
  localparam int DB_PER   = 24;

  typedef struct packed {
    logic [CNT_W-1:0] per;
    logic [CNT_W-1:0] fall;
    logic [CNT_W-1:0] rise;
    logic [EXP_W-1:0] dexp;
    logic [LIN_W-1:0] dlin;
  } pwm_set_t;
endpackage

// File: rtl/pwm_prescaler.sv
module pwm_prescaler #(
  parameter int LIN_W = 8,
  parameter int EXP_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic [LIN_W-1:0] div_lin,
  input  logic [EXP_W-1:0] div_exp,
  output logic             tick
);
  localparam int POW_W = (1 << EXP_W) - 1;

  logic [LIN_W-1:0] lin_q;
  logic [POW_W-1:0] pow_q;
  logic [POW_W-1:0] pow_lim;
  logic             lin_end;

  always_comb begin
    pow_lim = '0;
    for (int i = 0; i < POW_W; i++)
      if (i < int'(div_exp)) pow_lim[i] = 1'b1;
  end

  assign lin_end = (lin_q >= div_lin);
  assign tick    = run && lin_end && (pow_q >= pow_lim);

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      lin_q <= '0;
      pow_q <= '0;
    end else begin
      lin_q <= lin_end ? '0 : lin_q + 1'b1;
      if (lin_end) pow_q <= (pow_q >= pow_lim) ? '0 : pow_q + 1'b1;
    end
  end

  // R5: stopped prescaler is cleared
  a_r5_presc_clear: assert property (@(posedge clk) disable iff (rst)
    !run |=> (lin_q == '0 && pow_q == '0));
endmodule

// File: rtl/pwm_period_cnt.sv
module pwm_period_cnt #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic             tick,
  input  logic [CNT_W-1:0] period,
  output logic [CNT_W-1:0] cnt,
  output logic             wrap
);
  assign wrap = tick && (cnt >= period);

  always_ff @(posedge clk) begin
    if (rst || !run)  cnt <= '0;
    else if (wrap)    cnt <= '0;
    else if (tick)    cnt <= cnt + 1'b1;
  end

  // R2: counter only moves on a prescaler tick
  a_r2_hold_no_tick: assert property (@(posedge clk) disable iff (rst)
    (run && !tick) |=> $stable(cnt));
  // R5: counter forced to zero while stopped
  a_r5_cnt_zero: assert property (@(posedge clk) disable iff (rst)
    !run |=> (cnt == '0));
endmodule

// File: rtl/pwm_edge_window.sv
module pwm_edge_window #(
  parameter int CNT_W = 8
) (
  input  logic [CNT_W-1:0] cnt,
  input  logic [CNT_W-1:0] rise,
  input  logic [CNT_W-1:0] fall,
  output logic             active
);
  logic at_or_past_rise;
  logic before_fall;

  assign at_or_past_rise = (cnt >= rise);
  assign before_fall     = (cnt < fall);

  always_comb begin
    if (rise == fall)     active = 1'b1;
    else if (rise < fall) active = at_or_past_rise && before_fall;
    else                  active = at_or_past_rise || before_fall;
  end
endmodule

// File: rtl/pwm_edge_channel.sv
module pwm_edge_channel
  import pwm_edge_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        wr_ctrl,
  input  logic        wr_duty,
  input  logic [31:0] wdata,
  output logic        pwm_o
);
  logic     pin_en, inv, run, nosync;
  pwm_set_t stage_q, act_q;
  logic     tick, wrap, win;
  logic [CNT_W-1:0] cnt;
  logic     load_act;
  logic     unused_bits;

  assign unused_bits = ^{wdata[23:18], wdata[15], wdata[13]};
  assign load_act    = nosync || wrap || !run;

  always_ff @(posedge clk) begin
    if (rst) begin
      pin_en  <= 1'b0;
      inv     <= 1'b0;
      run     <= 1'b0;
      nosync  <= 1'b0;
      stage_q <= '0;
      act_q   <= '0;
    end else begin
      if (load_act) act_q <= stage_q;
      if (wr_ctrl) begin
        stage_q.dlin <= wdata[CB_LIN +: LIN_W];
        stage_q.dexp <= wdata[CB_EXP +: EXP_W];
        pin_en       <= wdata[CB_PIN];
        inv          <= wdata[CB_INV];
        run          <= wdata[CB_RUN];
        nosync       <= wdata[CB_NOSYN];
      end
      if (wr_duty) begin
        stage_q.rise <= wdata[DB_RISE +: CNT_W];
        stage_q.fall <= wdata[DB_FALL +: CNT_W];
        stage_q.per  <= wdata[DB_PER  +: CNT_W];
      end
    end
  end

  pwm_prescaler #(.LIN_W(LIN_W), .EXP_W(EXP_W)) u_presc (
    .clk(clk), .rst(rst), .run(run),
    .div_lin(act_q.dlin), .div_exp(act_q.dexp), .tick(tick)
  );

  pwm_period_cnt #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst(rst), .run(run), .tick(tick),
    .period(act_q.per), .cnt(cnt), .wrap(wrap)
  );

  pwm_edge_window #(.CNT_W(CNT_W)) u_win (
    .cnt(cnt), .rise(act_q.rise), .fall(act_q.fall), .active(win)
  );

  always_ff @(posedge clk) begin
    if (rst) pwm_o <= 1'b0;
    else     pwm_o <= pin_en & (inv ^ (win & run));
  end

  // R4: pin gate forces low output
  a_r4_pin_low: assert property (@(posedge clk) disable iff (rst)
    !pin_en |=> !pwm_o);
  // R8: with sync on, active set is held between boundaries
  a_r8_hold_shadow: assert property (@(posedge clk) disable iff (rst)
    (run && !nosync && !wrap) |=> $stable(act_q));
  // R7: equal points give a fully active window
  a_r7_full_duty: assert property (@(posedge clk) disable iff (rst)
    (run && pin_en && !inv && act_q.rise == act_q.fall) |=> pwm_o);
  // R5: stopped channel drives the inversion level only
  a_r5_stop_level: assert property (@(posedge clk) disable iff (rst)
    (!run && pin_en) |=> (pwm_o == $past(inv)));
endmodule

// File: tb/pwm_edge_channel_tb.sv
`timescale 1ns/1ps
module pwm_edge_channel_tb;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic wr_ctrl = 1'b0, wr_duty = 1'b0;
  logic [31:0] wdata = '0;
  logic pwm_o;

  int n_chk = 0, n_bad = 0, cyc = 0;
  bit done = 0;
  string phase = "R11 reset";

  always #5 clk = ~clk;

  pwm_edge_channel u_dut (.clk(clk), .rst(rst), .wr_ctrl(wr_ctrl),
    .wr_duty(wr_duty), .wdata(wdata), .pwm_o(pwm_o));

  // reference model built from the requirements
  logic [31:0] m_pc, m_pd;
  logic [7:0]  a_lin, a_per, a_rise, a_fall, m_lin, m_cnt;
  logic [3:0]  a_exp;
  logic [14:0] m_pow;
  logic        m_out;

  function automatic bit win_f(input logic [7:0] c, r, f);
    if (r == f) return 1'b1;
    if (r < f) return (c >= r) && (c < f);
    return (c >= r) || (c < f);
  endfunction

  always @(posedge clk) begin
    logic ce, tk, bnd, le;
    logic [14:0] lim;
    if (rst) begin
      m_pc <= '0; m_pd <= '0; a_lin <= '0; a_exp <= '0; a_per <= '0;
      a_rise <= '0; a_fall <= '0; m_lin <= '0; m_pow <= '0; m_cnt <= '0;
      m_out <= 1'b0;
    end else begin
      ce = m_pc[16];
      m_out <= m_pc[12] & (m_pc[14] ^ (win_f(m_cnt, a_rise, a_fall) & ce));
      lim = 15'((32'd1 << a_exp) - 1);
      le = (m_lin >= a_lin);
      tk = ce && le && (m_pow >= lim);
      bnd = tk && (m_cnt >= a_per);
      if (!ce) begin
        m_lin <= '0; m_pow <= '0; m_cnt <= '0;
      end else begin
        m_lin <= le ? 8'd0 : m_lin + 8'd1;
        if (le) m_pow <= (m_pow >= lim) ? 15'd0 : m_pow + 15'd1;
        if (bnd) m_cnt <= '0; else if (tk) m_cnt <= m_cnt + 8'd1;
      end
      if (m_pc[17] || bnd || !ce) begin
        a_lin <= m_pc[7:0]; a_exp <= m_pc[11:8];
        a_rise <= m_pd[7:0]; a_fall <= m_pd[15:8]; a_per <= m_pd[31:24];
      end
      if (wr_ctrl) m_pc <= wdata;
      if (wr_duty) m_pd <= wdata;
    end
  end

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (!rst && !done) begin
      n_chk++;
      if (pwm_o !== m_out) begin
        n_bad++;
        $display("FAIL %s cycle %0d: pwm_o=%b expected=%b", phase, cyc, pwm_o, m_out);
      end
    end
  end

  task automatic check(input string req, input int act, input int exp_v);
    n_chk++;
    if (act != exp_v) begin
      n_bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp_v);
    end
  endtask

  task automatic wr(input bit is_ctrl, input logic [31:0] d);
    wdata = d; wr_ctrl = is_ctrl; wr_duty = !is_ctrl;
    @(negedge clk);
    wr_ctrl = 1'b0; wr_duty = 1'b0;
  endtask

  function automatic logic [31:0] cw(int l, int e, bit pin, bit inv, bit run, bit ns);
    return (32'(ns) << 17) | (32'(run) << 16) | (32'(inv) << 14) |
           (32'(pin) << 12) | (32'(e & 15) << 8) | 32'(l & 255);
  endfunction

  function automatic logic [31:0] dw(int r, int f, int p);
    return (32'(p & 255) << 24) | (32'(f & 255) << 8) | 32'(r & 255);
  endfunction

  task automatic summary();
    if (!done) begin
      done = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired at cycle %0d", cyc);
      summary();
    end
  end

  initial begin
    int ones, rises;
    logic prev;
    void'($urandom(32'd2024));
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R11 reset output low", int'(pwm_o), 0);

    // R1/R3/R10: L=1 E=1 P=9, window 0..4 -> 40-clock period, 20 high
    phase = "R1 period";
    wr(0, dw(0, 5, 9));
    wr(1, cw(1, 1, 1, 0, 1, 1));
    repeat (100) @(negedge clk);
    ones = 0; rises = 0; prev = pwm_o;
    for (int i = 0; i < 400; i++) begin
      @(negedge clk);
      ones += int'(pwm_o);
      if (pwm_o && !prev) rises++;
      prev = pwm_o;
    end
    check("R1 high clocks in ten periods", ones, 200);
    check("R1 periods in 400 clocks", rises, 10);

    // R10: wrapped window, rise 7 fall 2, P=9 -> high counts 7,8,9,0,1
    phase = "R10 wrapped window";
    wr(0, dw(7, 2, 9));
    repeat (100) @(negedge clk);
    ones = 0;
    for (int i = 0; i < 400; i++) begin @(negedge clk); ones += int'(pwm_o); end
    check("R10 wrapped high clocks", ones, 200);

    // R7: equal points -> always high
    phase = "R7 full duty";
    wr(0, dw(4, 4, 9));
    repeat (100) @(negedge clk);
    ones = 0;
    for (int i = 0; i < 50; i++) begin @(negedge clk); ones += int'(pwm_o); end
    check("R7 always active", ones, 50);

    // R6: inversion takes effect one clock after the write
    phase = "R6 inversion";
    wdata = cw(1, 1, 1, 1, 1, 1); wr_ctrl = 1'b1;
    @(posedge clk); #1; wr_ctrl = 1'b0;
    @(posedge clk); #1;
    check("R6 inverted on next clock", int'(pwm_o), 0);
    @(negedge clk);

    // R4: pin enable clear with inversion set
    phase = "R4 pin gate";
    wr(1, cw(1, 1, 0, 1, 1, 1));
    repeat (60) @(negedge clk);
    check("R4 pin low with inversion", int'(pwm_o), 0);

    // R5: stop mid-period, then restart
    phase = "R5 run clear";
    wr(0, dw(0, 8, 9));
    wr(1, cw(1, 1, 1, 0, 1, 0));
    repeat (17) @(negedge clk);
    wr(1, cw(1, 1, 1, 0, 0, 0));
    @(negedge clk);
    check("R5 output stops at once", int'(pwm_o), 0);
    repeat (20) @(negedge clk);
    check("R5 stays low while stopped", int'(pwm_o), 0);

    // R8: sync on, new duty mid-period waits for the boundary
    phase = "R8 shadow update";
    wr(1, cw(3, 0, 1, 0, 1, 0));
    repeat (10) @(negedge clk);
    wr(0, dw(0, 1, 9));
    repeat (200) @(negedge clk);
    phase = "R9 immediate update";
    wr(1, cw(3, 0, 1, 0, 1, 1));
    wr(0, dw(2, 9, 9));
    repeat (200) @(negedge clk);

    // random configurations with occasional mid-run writes
    phase = "R2/R8/R9/R10 random";
    for (int k = 0; k < 40; k++) begin
      wr(0, dw($urandom_range(0, 15), $urandom_range(0, 15), $urandom_range(0, 15)));
      wr(1, cw($urandom_range(0, 3), $urandom_range(0, 2), ($urandom_range(0, 9) != 0),
               $urandom_range(0, 1), ($urandom_range(0, 7) != 0), $urandom_range(0, 1)));
      for (int t = 0; t < 300; t++) begin
        if ($urandom_range(0, 99) == 0)
          wr(0, dw($urandom_range(0, 15), $urandom_range(0, 15), $urandom_range(0, 15)));
        else
          @(negedge clk);
      end
    end
    summary();
  end
endmodule